// File: doc/BRIEF.md
# Ling Radix-4 Carry-Lookahead Adder

A purely combinational 32-bit adder. Two unsigned operands go in; a 32-bit sum and a carry-out come out in the same evaluation, with no clock, register or state. The carry network does not pass true carries. It passes Ling pseudo-carries, which use one term fewer per product than a group generate. A true carry is recovered only where a sum bit needs one, by ANDing the pseudo-carry with the propagate of the bit below.

Each bit forms a generate (a AND b) and an inclusive propagate (a OR b). Four-bit group cells build the pseudo-carry at every bit position from 1-, 2-, 3- and 4-input merge cells. Two 16-bit sections combine the four group terms inside each section with the same merge cells. The lower section's 16-bit-wide merge gives the single pseudo-carry that feeds the whole upper section. There is no carry-in: the carry into bit 0 is zero.

Top module: `ling_cla32`

## Requirements
- R1: `sum_o` equals the low 32 bits of the unsigned sum `a_i + b_i` for any operand pair.
- R2: `cout_o` equals bit 32 of the 33-bit unsigned sum `a_i + b_i`, that is 1 exactly when the sum exceeds 32'hFFFF_FFFF.
- R3: There is no carry-in. With both operands zero, `sum_o` is 0 and `cout_o` is 0.
- R4: A carry rippling across all 32 bits comes out correctly: 32'hFFFF_FFFF + 1 gives `sum_o` = 0 and `cout_o` = 1.
- R5: A carry crosses the boundary between the lower section (bits 0..15) and the upper section (bits 16..31): 32'h0000_FFFF + 1 gives 32'h0001_0000, and any mix of carries generated or propagated near bits 12..19 gives the arithmetic result.
- R6: Complementary operands (`b_i` = ~`a_i`, for example 32'hAAAA_AAAA with 32'h5555_5555) give `sum_o` = 32'hFFFF_FFFF and `cout_o` = 0. Equal alternating operands (32'hAAAA_AAAA twice) give 32'h5555_5554 with `cout_o` = 1.
- R7: The result does not depend on operand order: swapping `a_i` and `b_i` gives the same `sum_o` and `cout_o`.
- R8: The outputs settle combinationally. A change of the operands shows at the outputs without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First unsigned operand |
| b_i | input | 32 | Second unsigned operand |
| sum_o | output | 32 | Low 32 bits of the sum |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The block has no clock. The two functions that must coincide in one evaluation are the local pseudo-carry inside a 4-bit group and the long pseudo-carry coming from the 16-bit merge of the lower section. Upper-section bits combine both in the same expression. The bench provokes this overlap by sweeping every pair of 8-bit patterns placed across bits 12..19, once with the surrounding bits clear and once with them set. Each result is judged against the 33-bit arithmetic sum computed in the bench.

// File: rtl/ling_pkg.sv
package ling_pkg;

    localparam int DATA_W      = 32;
    localparam int GRP_W       = 4;
    localparam int SEC_W       = 16;
    localparam int N_GRP       = DATA_W / GRP_W;
    localparam int GRP_PER_SEC = SEC_W / GRP_W;
    localparam int N_SEC       = DATA_W / SEC_W;

    // A Ling span term: pseudo-carry of the span and the propagate
    // product shifted down by one bit (p of the bit below the span
    // through p of the second-highest bit of the span).
    typedef struct packed {
        logic h;
        logic ip;
    } ling_term_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              cout;
    } add_res_t;

    function automatic ling_term_t merge2(ling_term_t t1, ling_term_t t0);
        ling_term_t r;
        r.h  = t1.h | (t1.ip & t0.h);
        r.ip = t1.ip & t0.ip;
        return r;
    endfunction

    function automatic ling_term_t merge3(ling_term_t t2, ling_term_t t1,
                                          ling_term_t t0);
        ling_term_t r;
        r.h  = t2.h | (t2.ip & t1.h) | (t2.ip & t1.ip & t0.h);
        r.ip = t2.ip & t1.ip & t0.ip;
        return r;
    endfunction

    function automatic ling_term_t merge4(ling_term_t t3, ling_term_t t2,
                                          ling_term_t t1, ling_term_t t0);
        ling_term_t r;
        r.h  = t3.h | (t3.ip & t2.h) | (t3.ip & t2.ip & t1.h)
             | (t3.ip & t2.ip & t1.ip & t0.h);
        r.ip = t3.ip & t2.ip & t1.ip & t0.ip;
        return r;
    endfunction

endpackage

// File: rtl/ling_pg_bit.sv
module ling_pg_bit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] g_o,
    output logic [W-1:0] p_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign g_o[i] = a_i[i] & b_i[i];
        assign p_o[i] = a_i[i] | b_i[i];
    end
endmodule

// File: rtl/ling_group.sv
module ling_group
    import ling_pkg::*;
(
    input  logic [GRP_W-1:0] g_i,
    input  logic [GRP_W-2:0] p_i,
    input  logic             p_below_i,
    input  logic             h_in_i,
    output ling_term_t       term_o,
    output logic [GRP_W-1:0] h_o
);
    ling_term_t [GRP_W-1:0] bit_t;
    ling_term_t [GRP_W-1:0] loc_t;
    ling_term_t             in_t;

    always_comb begin
        bit_t[0].h  = g_i[0];
        bit_t[0].ip = p_below_i;
        for (int k = 1; k < GRP_W; k++) begin
            bit_t[k].h  = g_i[k];
            bit_t[k].ip = p_i[k-1];
        end
        loc_t[0] = bit_t[0];
        loc_t[1] = merge2(bit_t[1], bit_t[0]);
        loc_t[2] = merge3(bit_t[2], bit_t[1], bit_t[0]);
        loc_t[3] = merge4(bit_t[3], bit_t[2], bit_t[1], bit_t[0]);
        in_t.h  = h_in_i;
        in_t.ip = 1'b0;
        for (int k = 0; k < GRP_W; k++) begin
            h_o[k] = loc_t[k].h | (loc_t[k].ip & in_t.h);
        end
        term_o = loc_t[GRP_W-1];
    end
endmodule

// File: rtl/ling_section.sv
module ling_section
    import ling_pkg::*;
(
    input  ling_term_t [GRP_PER_SEC-1:0] term_i,
    input  logic                         h_in_i,
    output logic [GRP_PER_SEC-1:0]       h_end_o
);
    ling_term_t [GRP_PER_SEC-1:0] span_t;

    always_comb begin
        span_t[0] = term_i[0];
        span_t[1] = merge2(term_i[1], term_i[0]);
        span_t[2] = merge3(term_i[2], term_i[1], term_i[0]);
        // one 16-bit-wide merge: this output feeds the next section
        span_t[3] = merge4(term_i[3], term_i[2], term_i[1], term_i[0]);
        for (int k = 0; k < GRP_PER_SEC; k++) begin
            h_end_o[k] = span_t[k].h | (span_t[k].ip & h_in_i);
        end
    end
endmodule

// File: rtl/ling_cla32.sv
module ling_cla32
    import ling_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    logic [DATA_W-1:0]      g;
    logic [DATA_W-1:0]      p;
    logic [DATA_W-1:0]      hbit;
    logic [N_GRP-1:0]       grp_hend;
    ling_term_t [N_GRP-1:0] grp_t;
    add_res_t               res_d;

    ling_pg_bit #(.W(DATA_W)) u_pg (
        .a_i (a_i),
        .b_i (b_i),
        .g_o (g),
        .p_o (p)
    );

    for (genvar m = 0; m < N_GRP; m++) begin : g_grp
        logic p_below;
        logic h_in;
        if (m == 0) begin : g_first
            assign p_below = 1'b0;
            assign h_in    = 1'b0;
        end else begin : g_rest
            assign p_below = p[m*GRP_W-1];
            assign h_in    = grp_hend[m-1];
        end
        ling_group u_grp (
            .g_i       (g[m*GRP_W +: GRP_W]),
            .p_i       (p[m*GRP_W +: GRP_W-1]),
            .p_below_i (p_below),
            .h_in_i    (h_in),
            .term_o    (grp_t[m]),
            .h_o       (hbit[m*GRP_W +: GRP_W])
        );
    end

    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        logic                   h_in;
        logic [GRP_PER_SEC-1:0] h_end;
        if (s == 0) begin : g_first
            assign h_in = 1'b0;
        end else begin : g_rest
            assign h_in = g_sec[s-1].h_end[GRP_PER_SEC-1];
        end
        ling_section u_sec (
            .term_i  (grp_t[s*GRP_PER_SEC +: GRP_PER_SEC]),
            .h_in_i  (h_in),
            .h_end_o (h_end)
        );
        assign grp_hend[s*GRP_PER_SEC +: GRP_PER_SEC] = h_end;
    end

    // sum stage: true carry recovered as p(j-1) AND H(0,j-1)
    always_comb begin
        res_d.sum[0] = a_i[0] ^ b_i[0];
        for (int j = 1; j < DATA_W; j++) begin
            res_d.sum[j] = a_i[j] ^ b_i[j] ^ (p[j-1] & hbit[j-1]);
        end
        res_d.cout = p[DATA_W-1] & hbit[DATA_W-1];
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.cout;
endmodule

// File: rtl/ling_cla32_chk.sv
module ling_cla32_chk
    import ling_pkg::*;
(
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] sum_o,
    input logic              cout_o
);
    logic [DATA_W:0] ref_w;
    assign ref_w = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        a_r1_sum_matches: assert (sum_o == ref_w[DATA_W-1:0])
            else $error("R1 sum mismatch");
        a_r2_carry_matches: assert (cout_o == ref_w[DATA_W])
            else $error("R2 carry mismatch");
        a_r3_zero_in: assert (!((a_i == '0) && (b_i == '0)) || (sum_o == '0 && !cout_o))
            else $error("R3 zero operands");
        a_r4_full_ripple: assert (!((a_i == '1) && (b_i == 1)) || (sum_o == '0 && cout_o))
            else $error("R4 full ripple");
        a_r6_complement: assert (!(b_i == ~a_i) || (sum_o == '1 && !cout_o))
            else $error("R6 complement");
    end
endmodule

bind ling_cla32 ling_cla32_chk u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/ling_cla32_tb.sv
module ling_cla32_tb;
    logic        clk;
    logic        rst_n;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] sum;
    logic        cout;
    int          checks;
    int          errors;
    bit          done;

    ling_cla32 u_dut (
        .a_i    (a),
        .b_i    (b),
        .sum_o  (sum),
        .cout_o (cout)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic expect_val(string tag, logic [31:0] xs, logic xc,
                              logic [31:0] es, logic ec);
        checks++;
        if (xs !== es || xc !== ec) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual sum=%h cout=%b expected sum=%h cout=%b",
                     tag, a, b, xs, xc, es, ec);
        end
    endtask

    task automatic apply(string tag, logic [31:0] av, logic [31:0] bv);
        logic [32:0] ref_v;
        a = av;
        b = bv;
        #1;
        ref_v = {1'b0, av} + {1'b0, bv};
        expect_val(tag, sum, cout, ref_v[31:0], ref_v[32]);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        a = '0;
        b = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: zero plus zero, no carry-in
        a = '0; b = '0; #1;
        expect_val("R3 zero", sum, cout, 32'h0, 1'b0);
        // R4: full-length ripple
        a = 32'hFFFF_FFFF; b = 32'h1; #1;
        expect_val("R4 ones+1", sum, cout, 32'h0, 1'b1);
        // R5: section boundary
        a = 32'h0000_FFFF; b = 32'h1; #1;
        expect_val("R5 boundary", sum, cout, 32'h0001_0000, 1'b0);
        a = 32'h7FFF_FFFF; b = 32'h1; #1;
        expect_val("R5 long", sum, cout, 32'h8000_0000, 1'b0);
        // R6: alternating patterns
        a = 32'hAAAA_AAAA; b = 32'h5555_5555; #1;
        expect_val("R6 complement", sum, cout, 32'hFFFF_FFFF, 1'b0);
        a = 32'hAAAA_AAAA; b = 32'hAAAA_AAAA; #1;
        expect_val("R6 equal alt", sum, cout, 32'h5555_5554, 1'b1);
        // R2: carry-out edge cases
        a = 32'h8000_0000; b = 32'h8000_0000; #1;
        expect_val("R2 msb pair", sum, cout, 32'h0, 1'b1);
        a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; #1;
        expect_val("R2 max", sum, cout, 32'hFFFF_FFFE, 1'b1);
        // R8: change operands with no clock edge in between
        @(negedge clk);
        a = 32'h1234_5678; b = 32'h1111_1111; #1;
        expect_val("R8 settle1", sum, cout, 32'h2345_6789, 1'b0);
        a = 32'hF000_0000; b = 32'h1000_0001; #1;
        expect_val("R8 settle2", sum, cout, 32'h0000_0001, 1'b1);
        // R5: 8-bit window across bits 12..19, clear and set surroundings
        for (int fill = 0; fill < 2; fill++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic [31:0] base;
                    base = (fill == 1) ? 32'hFFF0_0FFF : 32'h0;
                    apply("R5 window", base | (32'(x) << 12),
                          (fill == 1 ? 32'h0000_0001 : 32'h0) | (32'(y) << 12));
                end
            end
        end
        // R1/R2 random vectors, R7 commutativity
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic [31:0] s1;
            logic        c1;
            ra = $urandom;
            rb = $urandom;
            apply("R1 R2 random", ra, rb);
            s1 = sum;
            c1 = cout;
            a = rb; b = ra; #1;
            expect_val("R7 swap", sum, cout, s1, c1);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule